// File: doc/BRIEF.md
# Programmable Down-Counter / Interval Timer

This block is a 16-bit down-counter that runs either as an event counter or as a free-running interval timer. A 3-bit mode field picks the operation together with the tick source: a rising edge on an external input, a one-cycle transmit clock enable from channel A or from channel B, or the system clock. Three of the modes pass the source through a divide-by-16 prescaler. Software writes a 16-bit preset as two bytes. It issues the start and stop commands by reading two dedicated addresses, so that no data has to be written to trigger them.

In counter modes, start loads the preset and the block counts down once per tick. When the count reaches zero it raises a ready flag and keeps counting through the wrap to all ones. Stop freezes the count and clears the flag. In timer modes the block reloads the preset at each terminal count and never stops, raising the ready flag each period. Stop then only clears the flag. The ready flag is visible in an interrupt status byte and is gated onto the interrupt output by a mask bit. The live count can be read as two bytes without tearing.

Top module: `ct_timer`

## Requirements
- R1: After reset the count is 0, the ready flag is clear, `irq` is low, the mode is 0 and reads of offsets 5, 6 and 7 return 0.
- R2: Bits 6:4 of a write to offset 4 set the mode. Mode 0 counts external rising edges, mode 1 counts `txa_tick` pulses, mode 2 counts `txb_tick` pulses and mode 3 counts the system clock divided by 16. A pulse from a source that is not selected leaves the count unchanged.
- R3: In modes 0 to 3, start loads the preset and each tick lowers the count by one. The tick that takes the count from 1 to 0 sets the ready flag. A tick at 0 wraps the count to 0xFFFF, and the ready flag stays set.
- R4: In modes 0 to 3, stop freezes the count against further ticks and clears the ready flag.
- R5: Mode 4 times external rising edges, mode 5 times external edges divided by 16, mode 6 times the system clock and mode 7 times the system clock divided by 16. In these modes a tick at a count of 1 or 0 reloads the preset and sets the ready flag, so a preset P gives a period of P ticks.
- R6: In modes 4 to 7, stop clears the ready flag and the count keeps running.
- R7: In modes 3, 5 and 7 a 4-bit prescaler passes one tick for every 16 source ticks, and start clears it. A restart therefore delays the first count by a full 16 source ticks.
- R8: The external input is counted once per low-to-high transition, however long it stays high.
- R9: A write to offset 6 sets the upper preset byte and a write to offset 7 sets the lower one. Reading offset 6 returns the upper count byte and captures the lower byte. The next read of offset 7 returns that captured byte; any later read of offset 7 returns the live lower byte.
- R10: Reading offset 5 returns the ready flag in bit 3 and zero elsewhere. Bit 3 of a write to offset 5 is the mask, and `irq` equals ready AND mask.
- R11: A read of offset 14 issues start and a read of offset 15 issues stop, each taking effect at the next clock edge. Writes to offsets 14 and 15 have no effect, and those reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe, one cycle; also carries the start/stop side effects |
| bus_rdata | output | DATA_W | Read data, combinational from the current state |
| ext_in | input | 1 | External count input, level |
| txa_tick | input | 1 | Channel A transmit clock enable |
| txb_tick | input | 1 | Channel B transmit clock enable |
| irq | output | 1 | Masked counter-ready interrupt |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, a 4-bit address and a 4-bit prescaler, so the divide-by-16 modes are tested at their real ratio. Because of the 16-bit width, a zero preset shows the full wrap to 0xFFFF after a single tick, and the byte-split read shows a carry from the upper byte within one cycle. Small presets with the system-clock modes place terminal counts, reloads and prescaler restarts at exact cycle offsets after the start read, and the tests sample at those offsets.

// File: rtl/ct_pkg.sv
package ct_pkg;

  // Mode field; the encoding is decoded by the tick selector and the core.
  typedef enum logic [2:0] {
    M_CNT_EXT   = 3'd0,
    M_CNT_TXA   = 3'd1,
    M_CNT_TXB   = 3'd2,
    M_CNT_SYS16 = 3'd3,
    M_TMR_EXT   = 3'd4,
    M_TMR_EXT16 = 3'd5,
    M_TMR_SYS   = 3'd6,
    M_TMR_SYS16 = 3'd7
  } ct_mode_e;

  // Register offsets
  localparam int OFS_AUX    = 4;
  localparam int OFS_INT    = 5;
  localparam int OFS_HI     = 6;
  localparam int OFS_LO     = 7;
  localparam int OFS_START  = 14;
  localparam int OFS_STOP   = 15;

  localparam int MODE_LSB   = 4;
  localparam int READY_BIT  = 3;

  function automatic logic is_timer(ct_mode_e m);
    return m inside {M_TMR_EXT, M_TMR_EXT16, M_TMR_SYS, M_TMR_SYS16};
  endfunction

  function automatic logic uses_prescale(ct_mode_e m);
    return m inside {M_CNT_SYS16, M_TMR_EXT16, M_TMR_SYS16};
  endfunction

  function automatic logic uses_ext(ct_mode_e m);
    return m inside {M_CNT_EXT, M_TMR_EXT, M_TMR_EXT16};
  endfunction

endpackage

// File: rtl/ct_tick_sel.sv
module ct_tick_sel
  import ct_pkg::*;
#(
  parameter int PRE_W = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  ct_mode_e mode,
  input  logic     ext_in,
  input  logic     txa_tick,
  input  logic     txb_tick,
  input  logic     pre_clr,
  output logic     tick
);

  localparam logic [PRE_W-1:0] PRE_LAST = '1;

  logic             ext_q;
  logic             ext_rise;
  logic             src;
  logic [PRE_W-1:0] pre;
  logic             pre_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_in;
  end

  assign ext_rise = ext_in & ~ext_q;

  always_comb begin
    if (uses_ext(mode))           src = ext_rise;
    else if (mode == M_CNT_TXA)   src = txa_tick;
    else if (mode == M_CNT_TXB)   src = txb_tick;
    else                          src = 1'b1;
  end

  assign pre_wrap = src && (pre == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             pre <= '0;
    else if (pre_clr)                       pre <= '0;
    else if (uses_prescale(mode) && src)    pre <= pre + 1'b1;
  end

  assign tick = uses_prescale(mode) ? pre_wrap : src;

  // R7: a divided tick is never followed by another one in the next cycle
  a_r7_prescale_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && uses_prescale(mode)) |=> (!tick || !uses_prescale(mode)));

  // R8: an external edge cannot produce ticks on two cycles in a row
  a_r8_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == M_CNT_EXT) |=> !(tick && mode == M_CNT_EXT));

endmodule

// File: rtl/ct_core.sv
module ct_core
  import ct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ct_mode_e         mode,
  input  logic             tick,
  input  logic             start,
  input  logic             stop,
  input  logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] count,
  output logic             ready
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // Terminal condition: counters end on 1->0, timers end at 1 or 0
  function automatic logic hits_term(logic tmr, logic [CNT_W-1:0] c);
    return tmr ? (c <= ONE) : (c == ONE);
  endfunction

  function automatic logic [CNT_W-1:0] step_val(logic tmr, logic [CNT_W-1:0] c,
                                                logic [CNT_W-1:0] p);
    return (tmr && c <= ONE) ? p : c - ONE;
  endfunction

  logic tmr;
  logic running;
  logic halt_req;
  logic step_en;
  logic term_evt;

  assign tmr      = is_timer(mode);
  assign halt_req = stop && !tmr;
  assign step_en  = running && tick && !halt_req;
  assign term_evt = step_en && hits_term(tmr, count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
      ready   <= 1'b0;
    end else if (start) begin
      count   <= preset;
      running <= 1'b1;
      ready   <= 1'b0;
    end else begin
      if (halt_req) running <= 1'b0;
      if (step_en)  count   <= step_val(tmr, count, preset);
      if (stop)          ready <= 1'b0;
      else if (term_evt) ready <= 1'b1;
    end
  end

  // R3: ready only rises after a cycle that carried a tick
  a_r3_ready_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(tick));

  // R4: a halted counter holds its value until the next start
  a_r4_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> $stable(count));

  // R4 / R6: stop leaves the ready flag clear
  a_r4_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !ready);

  // R5: timer terminal tick reloads the preset
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && is_timer(mode) && count <= ONE && !start)
      |=> count == $past(preset));

  // R6: stop in a timer mode does not halt the count
  a_r6_timer_runs_on: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && is_timer(mode) && !start) |=> running == $past(running));

endmodule

// File: rtl/ct_regs.sv
module ct_regs
  import ct_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_rd,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [2*DATA_W-1:0] count,
  input  logic                ready,
  output logic [2*DATA_W-1:0] preset,
  output ct_mode_e            mode,
  output logic                mask,
  output logic                start,
  output logic                stop
);

  localparam int CNT_W = 2 * DATA_W;

  logic              sel_aux, sel_int, sel_hi, sel_lo, sel_go, sel_halt;
  logic [DATA_W-1:0] lo_hold;
  logic              lo_valid;

  assign sel_aux  = bus_addr == ADDR_W'(OFS_AUX);
  assign sel_int  = bus_addr == ADDR_W'(OFS_INT);
  assign sel_hi   = bus_addr == ADDR_W'(OFS_HI);
  assign sel_lo   = bus_addr == ADDR_W'(OFS_LO);
  assign sel_go   = bus_addr == ADDR_W'(OFS_START);
  assign sel_halt = bus_addr == ADDR_W'(OFS_STOP);

  assign start = bus_rd && sel_go;
  assign stop  = bus_rd && sel_halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preset <= '0;
      mode   <= M_CNT_EXT;
      mask   <= 1'b0;
    end else if (bus_wr) begin
      if (sel_aux) mode <= ct_mode_e'(bus_wdata[MODE_LSB +: 3]);
      if (sel_int) mask <= bus_wdata[READY_BIT];
      if (sel_hi)  preset[CNT_W-1:DATA_W] <= bus_wdata;
      if (sel_lo)  preset[DATA_W-1:0]     <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_hold  <= '0;
      lo_valid <= 1'b0;
    end else if (bus_rd && sel_hi) begin
      lo_hold  <= count[DATA_W-1:0];
      lo_valid <= 1'b1;
    end else if (bus_rd && sel_lo) begin
      lo_valid <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_int)     bus_rdata[READY_BIT] = ready;
    else if (sel_hi) bus_rdata = count[CNT_W-1:DATA_W];
    else if (sel_lo) bus_rdata = lo_valid ? lo_hold : count[DATA_W-1:0];
  end

  // R11: the two commands never issue together
  a_r11_cmd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start, stop}));

  // R9: after an upper-byte read the captured lower byte is pending
  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel_hi) |=> (lo_valid && lo_hold == $past(count[DATA_W-1:0])));

endmodule

// File: rtl/ct_timer.sv
module ct_timer
  import ct_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int PRE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_in,
  input  logic              txa_tick,
  input  logic              txb_tick,
  output logic              irq
);

  localparam int CNT_W = 2 * DATA_W;

  ct_mode_e         mode;
  logic [CNT_W-1:0] preset;
  logic [CNT_W-1:0] count;
  logic             ready;
  logic             mask;
  logic             start;
  logic             stop;
  logic             tick;

  ct_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .count(count), .ready(ready),
    .preset(preset), .mode(mode), .mask(mask),
    .start(start), .stop(stop)
  );

  ct_tick_sel #(.PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .ext_in(ext_in), .txa_tick(txa_tick), .txb_tick(txb_tick),
    .pre_clr(start), .tick(tick)
  );

  ct_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tick(tick),
    .start(start), .stop(stop), .preset(preset),
    .count(count), .ready(ready)
  );

  assign irq = ready & mask;

  // R10: the interrupt is never raised without the ready flag
  a_r10_irq_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ready);

endmodule

// File: tb/tb_ct_timer.sv
`timescale 1ns/1ps
module tb_ct_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       ext_in = 1'b0;
  logic       txa_tick = 1'b0;
  logic       txb_tick = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       samp_ev;

  always #4 clk = ~clk;

  ct_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .ext_in(ext_in), .txa_tick(txa_tick), .txb_tick(txb_tick), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected read data and compares against the bus
  initial begin
    forever begin
      @(samp_ev);
      #1;
      if (exp_q.size() > 0) begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(bus_rdata === e, t, bus_rdata, e);
      end
    end
  end

  // All tasks enter and leave at a falling edge
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    -> samp_ev;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_ext(input int hold);
    ext_in = 1'b1; step(hold);
    ext_in = 1'b0; step(1);
  endtask

  task automatic pulse_a();
    txa_tick = 1'b1; step(1); txa_tick = 1'b0; step(1);
  endtask

  task automatic pulse_b();
    txb_tick = 1'b1; step(1); txb_tick = 1'b0; step(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    check(irq === 1'b0, "R1 irq after reset", irq, 0);
    rd(5, 8'h00, "R1 status after reset");
    rd(6, 8'h00, "R1 count hi after reset");
    rd(7, 8'h00, "R1 count lo after reset");

    // R11 writes to command offsets do nothing
    wr(6, 8'h00); wr(7, 8'h07);
    wr(14, 8'hFF); wr(15, 8'hFF);
    rd(7, 8'h00, "R11 write to start offset ignored");
    rd(14, 8'h00, "R11 start read returns 0");
    rd(7, 8'h07, "R11 start read loads preset");

    // R8 external edges, mode 0
    pulse_ext(4);
    rd(7, 8'h06, "R8 long high counts once");
    pulse_ext(1);
    rd(7, 8'h05, "R8 second edge");

    // R3 wrap from zero preset
    wr(7, 8'h00);
    rd(14, 8'h00, "R11 start");
    pulse_ext(1);
    rd(6, 8'hFF, "R3 wrap hi");
    rd(7, 8'hFF, "R3 wrap lo");
    rd(5, 8'h00, "R3 no ready on wrap");

    // R2 / R3 / R4 channel A source, mode 1
    wr(4, 8'h10); wr(7, 8'h02);
    rd(14, 8'h00, "R11 start");
    pulse_b();
    rd(7, 8'h02, "R2 channel B ignored in mode 1");
    pulse_a();
    rd(7, 8'h01, "R2 channel A counts");
    pulse_a();
    rd(5, 8'h08, "R3 ready at zero");
    wr(5, 8'h08);
    check(irq === 1'b1, "R10 irq with mask set", irq, 1);
    pulse_a();
    rd(7, 8'hFF, "R3 continues past zero");
    rd(5, 8'h08, "R3 ready held while counting on");
    rd(15, 8'h00, "R11 stop read returns 0");
    rd(5, 8'h00, "R4 stop clears ready");
    check(irq === 1'b0, "R10 irq drops with ready", irq, 0);
    pulse_a(); pulse_a();
    rd(6, 8'hFF, "R4 halted hi");
    rd(7, 8'hFF, "R4 halted lo");

    // R2 channel B source, mode 2
    wr(4, 8'h20); wr(6, 8'h00); wr(7, 8'h04);
    rd(14, 8'h00, "R11 start");
    pulse_a();
    rd(7, 8'h04, "R2 channel A ignored in mode 2");
    pulse_b();
    rd(7, 8'h03, "R2 channel B counts");

    // R7 system clock / 16, mode 3, restart clears prescaler
    wr(4, 8'h30); wr(7, 8'h02);
    rd(14, 8'h00, "R11 start");
    step(10);
    rd(14, 8'h00, "R11 restart");      // k = 0 on return
    step(15);                          // k = 15
    rd(7, 8'h02, "R7 no count before 16 clocks");   // k=15 -> 16
    rd(7, 8'h01, "R7 first divided tick");          // k=16 -> 17
    rd(5, 8'h00, "R7 not ready yet");               // k=17 -> 18
    step(14);                                        // k = 32
    rd(5, 8'h08, "R7 ready after 32 clocks");
    check(irq === 1'b1, "R10 irq in divided mode", irq, 1);

    // R7 / R5 external / 16 timer, mode 5
    wr(4, 8'h50); wr(7, 8'h01);
    rd(14, 8'h00, "R11 start");
    for (int i = 0; i < 15; i++) pulse_ext(1);
    rd(7, 8'h01, "R7 fifteen edges give no tick");
    rd(5, 8'h00, "R7 no ready before 16 edges");
    pulse_ext(1);
    rd(5, 8'h08, "R5 ready at terminal count");
    rd(7, 8'h01, "R5 reload of preset");

    // R5 / R6 system clock timer, mode 6, preset 3
    wr(4, 8'h60); wr(7, 8'h03);
    rd(14, 8'h00, "R11 start");        // k = 0
    step(2);                           // k = 2
    rd(5, 8'h00, "R5 not ready before period");     // k=2 -> 3
    rd(5, 8'h08, "R5 ready after 3 ticks");          // k=3 -> 4
    rd(15, 8'h00, "R11 stop read");                  // k=4 -> 5
    rd(5, 8'h00, "R6 stop clears ready");            // k=5 -> 6
    rd(7, 8'h03, "R6 count runs on and reloads");    // k=6 -> 7
    rd(5, 8'h08, "R6 ready again next period");
    wr(5, 8'h00);
    check(irq === 1'b0, "R10 irq masked off", irq, 0);

    // R9 coherent byte reads across a borrow
    wr(6, 8'h01); wr(7, 8'h00);
    rd(14, 8'h00, "R11 start");        // count 0x0100
    rd(6, 8'h01, "R9 upper byte");
    rd(7, 8'h00, "R9 captured lower byte");
    rd(7, 8'hFE, "R9 live lower byte afterwards");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule